// File: doc/BRIEF.md
# Execution Count Break Counter

This block qualifies the break requests of one debug break channel. A comparator outside the block emits a one-cycle match pulse whenever the channel's condition is satisfied. With counting turned off, every match is passed on as a break request. With counting turned on, each match uses up one unit of a 12-bit count that software has loaded. The break request is raised only for the match that arrives while the count already stands at one.

Software loads and reads the count through a 16-bit register port. Only the low twelve bits are stored. The top four bits read as zero, and anything written to them is discarded. The count never wraps below zero. When a bus write and a match arrive in the same cycle, the write wins. The break request is a registered pulse that appears one cycle after the match that qualifies it.

Top module: `exec_count_break`

## Requirements
- R1: While reset is held and after it is released, the stored count is 0 and `brk_req` is low.
- R2: A cycle with `reg_wr` high stores `reg_wdata[11:0]` as the count. With `reg_rd` high, `reg_rdata` shows the count in bits 11:0. With `reg_rd` low, `reg_rdata` is all zeros.
- R3: Bits 15:12 of `reg_rdata` always read 0, and the value written to `reg_wdata[15:12]` has no effect on the stored count.
- R4: With `cnt_mode` high, a match with no write and a count above 1 lowers the count by one and raises no break request.
- R5: With `cnt_mode` high, a match with no write and a count of exactly 1 sets the count to 0 and raises `brk_req` in the next cycle.
- R6: With `cnt_mode` high, a match while the count is 0 leaves the count at 0 and raises no break request.
- R7: With `cnt_mode` low, every match raises `brk_req` in the next cycle, and the count is left unchanged.
- R8: When `reg_wr` and `match` are high in the same cycle, the written value is stored. With `cnt_mode` high, that match causes no decrement and no break request.
- R9: `brk_req` is high for exactly one cycle for each qualifying match, in the cycle after it, and is never high unless a match occurred in the previous cycle.
- R10: A loaded count of 4095 (0xFFF) absorbs 4094 matches with no break, and the 4095th match raises `brk_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the count register |
| reg_wdata | input | 16 | Write data; bits 11:0 are the count |
| reg_rd | input | 1 | Read strobe for the count register |
| reg_rdata | output | 16 | Read data; bits 15:12 are zero |
| cnt_mode | input | 1 | Enables execution-count qualification |
| match | input | 1 | One-cycle pulse from the channel comparator |
| brk_req | output | 1 | One-cycle break request, registered |

## Verification
Matches are driven in four regimes, and each one separates a different behaviour:
- With the mode off, matches come in bursts and back to back. This shows that breaks pass straight through and that the count is left alone.
- With the mode on, the count starts above one and is run down through one to zero. This shows where the decrement happens, where the break fires, and that the count stops at zero.
- Matches land on the same cycle as a write, in both modes. This shows that the write takes priority.
- A full 4095 count is run down. This exposes width and terminal-count errors.

The read port is checked after every phase, with nonzero reserved write bits, so a stale or corrupted count shows up at the pins.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  // Action taken on the count register in a given cycle
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/ecb_rst_sync.sv
// Asserts asynchronously, releases on the clock after STAGES flops
module ecb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/ecb_decider.sv
// Decides the count action and whether this match qualifies for a break
module ecb_decider
  import ecb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             wr_en,
  input  logic             mode_en,
  input  logic             match,
  output cnt_act_e         act,
  output logic             fire
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic cnt_zero;
  logic cnt_last;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_ONE);

  always_comb begin
    act  = ACT_HOLD;
    fire = 1'b0;
    if (wr_en) begin
      act = ACT_LOAD;
    end
    if (mode_en) begin
      // A write in the same cycle swallows the match
      if (!wr_en && match && !cnt_zero) begin
        act  = ACT_DEC;
        fire = cnt_last;
      end
    end else begin
      fire = match;
    end
  end
endmodule

// File: rtl/ecb_count_reg.sv
// Holds the count; separate next-state and register processes
module ecb_count_reg
  import ecb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_act_e         act,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    unique case (act)
      ACT_LOAD: cnt_d = load_val;
      ACT_DEC:  cnt_d = cnt_q - CNT_STEP;
      default:  cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = (act != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ecb_pulse_reg.sv
// Registers the qualified match into a one-cycle break pulse
module ecb_pulse_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_q
);
  logic pulse_d;

  always_comb pulse_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end
endmodule

// File: rtl/exec_count_break.sv
module exec_count_break
  import ecb_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rd,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             cnt_mode,
  input  logic             match,
  output logic             brk_req
);
  localparam int RSV_W = REG_W - CNT_W;

  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  cnt_act_e         act;
  logic             fire;
  logic             wdata_unused;

  // Reserved write bits are dropped here
  assign load_val     = reg_wdata[CNT_W-1:0];
  assign wdata_unused = ^reg_wdata[REG_W-1:CNT_W];

  ecb_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  ecb_decider #(.CNT_W(CNT_W)) u_dec (
    .cnt_q   (cnt_q),
    .wr_en   (reg_wr),
    .mode_en (cnt_mode),
    .match   (match),
    .act     (act),
    .fire    (fire)
  );

  ecb_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .act      (act),
    .load_val (load_val),
    .cnt_q    (cnt_q)
  );

  ecb_pulse_reg u_pls (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (fire),
    .pulse_q (brk_req)
  );

  assign reg_rdata = reg_rd ? {{RSV_W{1'b0}}, cnt_q} : '0;
endmodule

// File: rtl/exec_count_break_chk.sv
module exec_count_break_chk #(
  parameter int REG_W = 16,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             cnt_mode,
  input logic             match,
  input logic             brk_req,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R3
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:CNT_W] == '0);

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> cnt_q == $past(reg_wdata[CNT_W-1:0]));

  // R7
  direct_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_mode && match) |=> brk_req);

  // R7
  direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_mode && !reg_wr) |=> $stable(cnt_q));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reg_wr) |=> cnt_q == '0);

  // R9
  break_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(match));

  // R5
  last_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && match && !reg_wr && cnt_q == ONE) |=> (brk_req && cnt_q == '0));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && match && !reg_wr && cnt_q > ONE) |=>
      (!brk_req && cnt_q == $past(cnt_q) - ONE));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && match && reg_wr) |=> !brk_req);
endmodule

bind exec_count_break exec_count_break_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cnt_mode  (cnt_mode),
  .match     (match),
  .brk_req   (brk_req),
  .cnt_q     (cnt_q)
);

// File: tb/exec_count_break_test.sv
module exec_count_break_test;
  localparam int CLK_HALF = 2;  // 250 MHz

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic        reg_rd;
  logic [15:0] reg_rdata;
  logic        cnt_mode;
  logic        match;
  logic        brk_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic  brk;
    string tag;
  } exp_item_t;

  exp_item_t sb[$];
  logic [11:0] m_cnt;
  logic        cur_mode;

  always #CLK_HALF clk = ~clk;

  exec_count_break uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .cnt_mode  (cnt_mode),
    .match     (match),
    .brk_req   (brk_req)
  );

  // Monitor: one cycle after each driven cycle, compare the break output
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_item_t it;
      it = sb.pop_front();
      total++;
      if (brk_req !== it.brk) begin
        bad++;
        $display("FAIL %s brk_req actual=%b expected=%b", it.tag, brk_req, it.brk);
      end
    end
  end

  // Driver: apply one cycle of stimulus and push the expected break
  task automatic step(input logic wr, input logic [15:0] wd, input logic rd,
                      input logic mt, input string tag);
    exp_item_t it;
    @(negedge clk);
    reg_wr    = wr;
    reg_wdata = wd;
    reg_rd    = rd;
    cnt_mode  = cur_mode;
    match     = mt;
    it.brk = 1'b0;
    it.tag = tag;
    if (cur_mode) begin
      if (wr) m_cnt = wd[11:0];
      else if (mt && m_cnt != 12'd0) begin
        it.brk = (m_cnt == 12'd1);
        m_cnt  = m_cnt - 12'd1;
      end
    end else begin
      if (mt) it.brk = 1'b1;
      if (wr) m_cnt = wd[11:0];
    end
    sb.push_back(it);
  endtask

  task automatic read_chk(input string tag);
    step(1'b0, 16'h0, 1'b1, 1'b0, tag);
    #1;
    total++;
    if (reg_rdata !== {4'h0, m_cnt}) begin
      bad++;
      $display("FAIL %s reg_rdata actual=%h expected=%h", tag, reg_rdata, {4'h0, m_cnt});
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; reg_rd = 1'b0;
    cnt_mode = 1'b0; match = 1'b0; cur_mode = 1'b0; m_cnt = '0;
    repeat (3) @(negedge clk);
    total++;
    if (brk_req !== 1'b0) begin
      bad++; $display("FAIL R1 brk_req in reset actual=%b expected=0", brk_req);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R1 count after reset");

    // R2 plain write then read; R2 read strobe low gives zero
    step(1'b1, 16'h0123, 1'b0, 1'b0, "R2 write");
    read_chk("R2 readback");
    step(1'b0, 16'h0, 1'b0, 1'b0, "R2 idle");
    #1; total++;
    if (reg_rdata !== 16'h0) begin
      bad++; $display("FAIL R2 rdata with rd low actual=%h expected=0000", reg_rdata);
    end

    // R3 reserved bits discarded
    step(1'b1, 16'hF456, 1'b0, 1'b0, "R3 write reserved");
    read_chk("R3 readback");

    // R7 direct mode, bursts and back-to-back matches
    step(1'b1, 16'hA005, 1'b0, 1'b0, "R7 load");
    for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 1'b0, 1'b1, "R7 direct match");
    step(1'b0, 16'h0, 1'b0, 1'b0, "R9 idle after burst");
    step(1'b0, 16'h0, 1'b0, 1'b1, "R7 isolated match");
    read_chk("R7 count unchanged");

    // R4 count mode decrement, R5 break at one, R6 stop at zero
    cur_mode = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 1'b0, 1'b1, "R4 decrement");
    read_chk("R4 count at one");
    step(1'b0, 16'h0, 1'b0, 1'b1, "R5 terminal match");
    step(1'b0, 16'h0, 1'b0, 1'b0, "R9 single pulse");
    read_chk("R5 count zero");
    step(1'b0, 16'h0, 1'b0, 1'b1, "R6 match at zero");
    step(1'b0, 16'h0, 1'b0, 1'b1, "R6 match at zero");
    read_chk("R6 still zero");

    // R8 write and match together, both modes
    cur_mode = 1'b0;
    step(1'b1, 16'h7003, 1'b0, 1'b1, "R8 write+match direct");
    read_chk("R8 value after direct");
    cur_mode = 1'b1;
    step(1'b1, 16'h0001, 1'b0, 1'b1, "R8 write+match counting");
    read_chk("R8 written one kept");
    step(1'b0, 16'h0, 1'b0, 1'b1, "R8 next match breaks");
    read_chk("R8 zero after break");

    // R10 full count
    step(1'b1, 16'h0FFF, 1'b0, 1'b0, "R10 load max");
    for (int i = 0; i < 4094; i++) step(1'b0, 16'h0, 1'b0, 1'b1, "R10 run down");
    read_chk("R10 at one");
    step(1'b0, 16'h0, 1'b0, 1'b1, "R10 final match");
    read_chk("R10 zero");

    repeat (4) step(1'b0, 16'h0, 1'b0, 1'b0, "R9 drain");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule